// File: doc/BRIEF.md
# External Interrupt Pending/Active Tracker

This block holds the per-line interrupt state for a bank of external interrupt inputs. For each line it keeps a synchronised copy of the input level, a pending bit, an active bit and an enable bit. A separate priority selector reads the pending, active and enable vectors and picks a winner. The core then tells this block when it takes an exception (acknowledge) and when the handler returns (completion). External line `n` is known to the rest of the system as exception number `n + 16`. Acknowledge, completion and the software trigger all use that numbering.

Software reaches the state through a narrow register-operation port. Enable and pending bits are set or cleared by bitmask writes. The active vector can be read but not written. A trigger operation pends one line by its number. An input that rises latches pending. An input that is still high when its handler completes is pended again, so a level-held request runs its handler until the source drops.

Top module: `xirq_tracker`

## Requirements
- R1: After reset the pending, active and enable vectors are all zero.
- R2: Each input passes through two synchronising flops. A rising edge of the synchronised level sets the line's pending bit on the third rising clock edge after the input changes. A falling edge never clears pending.
- R3: Line `n` is addressed as exception number `n + 16` by acknowledge, completion and trigger. Numbers below 16 or at and above `16 + NUM_LINES` match no line.
- R4: An acknowledge of a pending line clears its pending bit and sets its active bit on the same clock edge. An acknowledge of a line that is not pending, or of a number that matches no line, changes nothing.
- R5: A completion whose number matches no active line raises `cmp_err` in the same cycle and changes no state.
- R6: A valid completion clears the line's active bit. If the synchronised level of that line is high, the same edge sets its pending bit again.
- R7: `cmp_to_base` is 1 when at most one line is active, judged from the active vector before the completion takes effect.
- R8: Operation code 0 sets and code 1 clears enable bits. Bit `b` of the data in word `w` addresses line `32*w + b`. Zero data bits leave their lines unchanged.
- R9: Operation code 2 sets and code 3 clears pending bits, with the same word and bit mapping as R8 and no effect from zero bits.
- R10: A read with code 0 or 1 returns the enable word, a read with code 2 or 3 returns the pending word, and a read with code 4 returns the active word. Bits for lines that are not implemented read as 0.
- R11: A write with operation code 4, which addresses the active vector, is ignored.
- R12: A write with operation code 5 pends exception `data[8:0] + 16` if that number matches a line. The write takes effect when `priv_mode` is 1 or `user_pend_en` is 1, and is dropped otherwise.
- R13: When a set of pending and a clear of pending reach the same line on the same edge, the set wins. Set sources are an edge, a software set, a trigger or a re-pend. Clear sources are an acknowledge or a software clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_in | input | NUM_LINES | Raw external interrupt levels |
| ack_valid | input | 1 | Acknowledge request |
| ack_exc | input | 10 | Exception number being acknowledged |
| cmp_valid | input | 1 | Completion (handler return) request |
| cmp_exc | input | 10 | Exception number being completed |
| cmp_err | output | 1 | Completion names no active line (combinational) |
| cmp_to_base | output | 1 | At most one line active before this completion |
| wr_en | input | 1 | Register write strobe |
| wr_op | input | 3 | Write operation code |
| wr_word | input | WIDX_W | Word index for bitmask writes |
| wr_data | input | 32 | Write data |
| priv_mode | input | 1 | Writer is privileged |
| user_pend_en | input | 1 | Unprivileged trigger writes permitted |
| rd_op | input | 3 | Read selector code |
| rd_word | input | WIDX_W | Read word index |
| rd_data | output | 32 | Read data (combinational) |
| pend_o | output | NUM_LINES | Pending vector |
| act_o | output | NUM_LINES | Active vector |
| en_o | output | NUM_LINES | Enable vector |

## Verification
The assertions assume two things about the neighbours. The priority selector never acknowledges and completes the same line in the same cycle. At most one software operation arrives per cycle, because the port carries a single operation code. The stimulus issues acknowledge, completion and register writes one at a time, except in the deliberate collision case for R13. It changes raw inputs only when no other event is in flight, and then waits out the synchroniser latency before the next operation. This lets the active-vector stability properties rely on no acknowledge coinciding with the checked event.

// File: rtl/xirq_pkg.sv
`timescale 1ns/1ps
package xirq_pkg;
  localparam int EXC_W    = 10;
  localparam int EXC_BASE = 16;
  localparam int TRIG_W   = 9;
  localparam int WORD_W   = 32;

  typedef enum logic [2:0] {
    OP_SETEN   = 3'd0,
    OP_CLREN   = 3'd1,
    OP_SETPEND = 3'd2,
    OP_CLRPEND = 3'd3,
    OP_ACTIVE  = 3'd4,
    OP_TRIGGER = 3'd5
  } xirq_op_e;

  // exception number seen by the core for a given line index
  function automatic logic [EXC_W-1:0] exc_of_line(input int unsigned n);
    return EXC_W'(n + EXC_BASE);
  endfunction

  // exception number named by the trigger field
  function automatic logic [EXC_W-1:0] trig_target(input logic [TRIG_W-1:0] f);
    return EXC_W'(f) + EXC_W'(EXC_BASE);
  endfunction
endpackage

// File: rtl/xirq_sync.sv
`timescale 1ns/1ps
module xirq_sync #(
  parameter int NUM_LINES = 40,
  parameter int STAGES    = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_LINES-1:0] raw,
  output logic [NUM_LINES-1:0] level,
  output logic [NUM_LINES-1:0] rise
);
  logic [STAGES-1:0][NUM_LINES-1:0] chain;
  logic [NUM_LINES-1:0]             prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain[0] <= '0;
    else        chain[0] <= raw;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain[s] <= '0;
      else        chain[s] <= chain[s-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev <= '0;
    else        prev <= chain[STAGES-1];
  end

  assign level = chain[STAGES-1];
  assign rise  = chain[STAGES-1] & ~prev;
endmodule

// File: rtl/xirq_swdecode.sv
`timescale 1ns/1ps
module xirq_swdecode
  import xirq_pkg::*;
#(
  parameter int NUM_LINES = 40,
  parameter int WIDX_W    = 1
) (
  input  logic                 wr_en,
  input  logic [2:0]           wr_op,
  input  logic [WIDX_W-1:0]    wr_word,
  input  logic [WORD_W-1:0]    wr_data,
  input  logic                 priv_mode,
  input  logic                 user_pend_en,
  output logic [NUM_LINES-1:0] en_set,
  output logic [NUM_LINES-1:0] en_clr,
  output logic [NUM_LINES-1:0] pend_set,
  output logic [NUM_LINES-1:0] pend_clr
);
  logic trig_ok;
  logic [EXC_W-1:0] trig_exc;

  assign trig_ok  = wr_en && (wr_op == OP_TRIGGER) && (priv_mode || user_pend_en);
  assign trig_exc = trig_target(wr_data[TRIG_W-1:0]);

  for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
    localparam int W = i / WORD_W;
    localparam int B = i % WORD_W;
    logic hit;
    assign hit         = wr_en && (wr_word == WIDX_W'(W)) && wr_data[B];
    assign en_set[i]   = hit && (wr_op == OP_SETEN);
    assign en_clr[i]   = hit && (wr_op == OP_CLREN);
    assign pend_clr[i] = hit && (wr_op == OP_CLRPEND);
    assign pend_set[i] = (hit && (wr_op == OP_SETPEND)) ||
                         (trig_ok && (trig_exc == exc_of_line(i)));
  end
endmodule

// File: rtl/xirq_cell.sv
`timescale 1ns/1ps
module xirq_cell (
  input  logic clk,
  input  logic rst_n,
  input  logic rise,
  input  logic level,
  input  logic en_set,
  input  logic en_clr,
  input  logic pend_set,
  input  logic pend_clr,
  input  logic ack_take,
  input  logic cmp_take,
  output logic pend,
  output logic act,
  output logic en
);
  logic set_p, clr_p;

  // any set source beats any clear source on the same edge
  assign set_p = rise | pend_set | (cmp_take & level);
  assign clr_p = pend_clr | ack_take;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend <= 1'b0;
      act  <= 1'b0;
      en   <= 1'b0;
    end else begin
      pend <= (pend & ~clr_p) | set_p;
      act  <= (act & ~cmp_take) | ack_take;
      en   <= (en & ~en_clr) | en_set;
    end
  end
endmodule

// File: rtl/xirq_tracker.sv
`timescale 1ns/1ps
module xirq_tracker
  import xirq_pkg::*;
#(
  parameter  int NUM_LINES = 40,
  localparam int WORDS     = (NUM_LINES + WORD_W - 1) / WORD_W,
  localparam int WIDX_W    = (WORDS > 1) ? $clog2(WORDS) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_LINES-1:0] irq_in,
  input  logic                 ack_valid,
  input  logic [EXC_W-1:0]     ack_exc,
  input  logic                 cmp_valid,
  input  logic [EXC_W-1:0]     cmp_exc,
  output logic                 cmp_err,
  output logic                 cmp_to_base,
  input  logic                 wr_en,
  input  logic [2:0]           wr_op,
  input  logic [WIDX_W-1:0]    wr_word,
  input  logic [WORD_W-1:0]    wr_data,
  input  logic                 priv_mode,
  input  logic                 user_pend_en,
  input  logic [2:0]           rd_op,
  input  logic [WIDX_W-1:0]    rd_word,
  output logic [WORD_W-1:0]    rd_data,
  output logic [NUM_LINES-1:0] pend_o,
  output logic [NUM_LINES-1:0] act_o,
  output logic [NUM_LINES-1:0] en_o
);
  localparam int PAD_W = WORDS * WORD_W;

  // at most one line active
  function automatic logic at_base(input logic [NUM_LINES-1:0] a);
    int unsigned n = 0;
    for (int k = 0; k < NUM_LINES; k++) n += 32'(a[k]);
    return n <= 1;
  endfunction

  logic [NUM_LINES-1:0] level_w, rise_w;
  logic [NUM_LINES-1:0] en_set, en_clr, pend_set, pend_clr;
  logic [NUM_LINES-1:0] ack_take, cmp_take;

  xirq_sync #(.NUM_LINES(NUM_LINES), .STAGES(2)) u_sync (
    .clk(clk), .rst_n(rst_n), .raw(irq_in), .level(level_w), .rise(rise_w)
  );

  xirq_swdecode #(.NUM_LINES(NUM_LINES), .WIDX_W(WIDX_W)) u_dec (
    .wr_en(wr_en), .wr_op(wr_op), .wr_word(wr_word), .wr_data(wr_data),
    .priv_mode(priv_mode), .user_pend_en(user_pend_en),
    .en_set(en_set), .en_clr(en_clr), .pend_set(pend_set), .pend_clr(pend_clr)
  );

  for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
    assign ack_take[i] = ack_valid && (ack_exc == exc_of_line(i)) && pend_o[i];
    assign cmp_take[i] = cmp_valid && (cmp_exc == exc_of_line(i)) && act_o[i];

    xirq_cell u_cell (
      .clk(clk), .rst_n(rst_n),
      .rise(rise_w[i]), .level(level_w[i]),
      .en_set(en_set[i]), .en_clr(en_clr[i]),
      .pend_set(pend_set[i]), .pend_clr(pend_clr[i]),
      .ack_take(ack_take[i]), .cmp_take(cmp_take[i]),
      .pend(pend_o[i]), .act(act_o[i]), .en(en_o[i])
    );
  end

  assign cmp_err     = cmp_valid && (cmp_take == '0);
  assign cmp_to_base = at_base(act_o);

  logic [PAD_W-1:0] src_pad;
  always_comb begin
    src_pad = '0;
    case (rd_op)
      OP_SETEN, OP_CLREN:     src_pad[NUM_LINES-1:0] = en_o;
      OP_SETPEND, OP_CLRPEND: src_pad[NUM_LINES-1:0] = pend_o;
      OP_ACTIVE:              src_pad[NUM_LINES-1:0] = act_o;
      default:                src_pad = '0;
    endcase
    if (32'(rd_word) < WORDS) rd_data = src_pad[rd_word*WORD_W +: WORD_W];
    else                      rd_data = '0;
  end
endmodule

// File: rtl/xirq_checker.sv
`timescale 1ns/1ps
module xirq_checker
  import xirq_pkg::*;
#(
  parameter int NUM_LINES = 40
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [NUM_LINES-1:0] rise,
  input logic [NUM_LINES-1:0] level,
  input logic [NUM_LINES-1:0] pend,
  input logic [NUM_LINES-1:0] act,
  input logic [NUM_LINES-1:0] ack_take,
  input logic [NUM_LINES-1:0] cmp_take,
  input logic                 ack_valid,
  input logic                 cmp_valid,
  input logic                 cmp_err,
  input logic                 wr_en,
  input logic [2:0]           wr_op
);
  AST_RISE_PENDS: assert property (@(posedge clk) disable iff (!rst_n)
    (rise != '0) |=> ((pend & $past(rise)) == $past(rise))); // R2

  AST_ACK_ONE_LINE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ack_take)); // R3

  AST_ACK_TO_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_take != '0) |=> ((act & $past(ack_take)) == $past(ack_take))); // R4

  AST_ILLEGAL_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_valid && cmp_err && !ack_valid) |=> $stable(act)); // R5

  AST_CMP_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    ((cmp_take != '0) && (ack_take == '0)) |=> ((act & $past(cmp_take)) == '0)); // R6

  AST_REPEND: assert property (@(posedge clk) disable iff (!rst_n)
    ((cmp_take & level) != '0) |=>
      ((pend & $past(cmp_take & level)) == $past(cmp_take & level))); // R6

  AST_ACTIVE_WR_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (wr_op == OP_ACTIVE) && !ack_valid && !cmp_valid) |=> $stable(act)); // R11
endmodule

bind xirq_tracker xirq_checker #(.NUM_LINES(NUM_LINES)) u_chk (
  .clk(clk), .rst_n(rst_n), .rise(rise_w), .level(level_w),
  .pend(pend_o), .act(act_o), .ack_take(ack_take), .cmp_take(cmp_take),
  .ack_valid(ack_valid), .cmp_valid(cmp_valid), .cmp_err(cmp_err),
  .wr_en(wr_en), .wr_op(wr_op)
);

// File: tb/xirq_tracker_tb_top.sv
`timescale 1ns/1ps
module xirq_tracker_tb_top;
  localparam int NL = 40;
  localparam int WIDX_W = 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NL-1:0] irq_in = '0;
  logic ack_valid = 1'b0, cmp_valid = 1'b0;
  logic [9:0] ack_exc = '0, cmp_exc = '0;
  logic cmp_err, cmp_to_base;
  logic wr_en = 1'b0;
  logic [2:0] wr_op = '0;
  logic [WIDX_W-1:0] wr_word = '0;
  logic [31:0] wr_data = '0;
  logic priv_mode = 1'b1, user_pend_en = 1'b0;
  logic [2:0] rd_op = '0;
  logic [WIDX_W-1:0] rd_word = '0;
  logic [31:0] rd_data;
  logic [NL-1:0] pend_o, act_o, en_o;

  logic [NL-1:0] mpend = '0, mact = '0, men = '0;
  int nchk = 0, nerr = 0;
  bit done = 0;

  always #10 clk = ~clk;

  xirq_tracker #(.NUM_LINES(NL)) dut_i (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in),
    .ack_valid(ack_valid), .ack_exc(ack_exc),
    .cmp_valid(cmp_valid), .cmp_exc(cmp_exc),
    .cmp_err(cmp_err), .cmp_to_base(cmp_to_base),
    .wr_en(wr_en), .wr_op(wr_op), .wr_word(wr_word), .wr_data(wr_data),
    .priv_mode(priv_mode), .user_pend_en(user_pend_en),
    .rd_op(rd_op), .rd_word(rd_word), .rd_data(rd_data),
    .pend_o(pend_o), .act_o(act_o), .en_o(en_o)
  );

  task automatic check(input string tag, input logic [63:0] got, input logic [63:0] exp);
    nchk++;
    if (got !== exp) begin
      nerr++;
      $display("FAIL %s: actual %h expected %h", tag, got, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  function automatic logic [NL-1:0] mask_of(input int w, input logic [31:0] d);
    logic [NL-1:0] m = '0;
    for (int l = 0; l < NL; l++) if (l / 32 == w) m[l] = d[l % 32];
    return m;
  endfunction

  task automatic check_state(input string tag);
    check({tag, " pending"}, 64'(pend_o), 64'(mpend));
    check({tag, " active"},  64'(act_o),  64'(mact));
    check({tag, " enable"},  64'(en_o),   64'(men));
  endtask

  task automatic check_reads(input string tag);
    for (int op = 0; op < 6; op++) begin
      for (int w = 0; w < 2; w++) begin
        logic [NL-1:0] src;
        logic [31:0] exp = '0;
        case (op)
          0, 1: src = men;
          2, 3: src = mpend;
          4:    src = mact;
          default: src = '0;
        endcase
        for (int b = 0; b < 32; b++) if (w * 32 + b < NL) exp[b] = src[w * 32 + b];
        rd_op = 3'(op); rd_word = WIDX_W'(w);
        #1;
        check({tag, " R10 read"}, 64'(rd_data), 64'(exp));
      end
    end
  endtask

  task automatic wr(input int op, input int w, input logic [31:0] d);
    logic [NL-1:0] m = mask_of(w, d);
    wr_en = 1'b1; wr_op = 3'(op); wr_word = WIDX_W'(w); wr_data = d;
    step();
    wr_en = 1'b0;
    case (op)
      0: men   = men | m;
      1: men   = men & ~m;
      2: mpend = mpend | m;
      3: mpend = mpend & ~m;
      5: begin
        int f = int'(d[8:0]);
        if (f < NL && (priv_mode || user_pend_en)) mpend[f] = 1'b1;
      end
      default: ;
    endcase
  endtask

  task automatic do_ack(input int exc);
    ack_valid = 1'b1; ack_exc = 10'(exc);
    step();
    ack_valid = 1'b0;
    if (exc >= 16 && exc - 16 < NL && mpend[exc - 16]) begin
      mact[exc - 16] = 1'b1; mpend[exc - 16] = 1'b0;
    end
  endtask

  task automatic do_cmp(input int exc);
    int l = exc - 16;
    bit ok = (exc >= 16 && l < NL) ? mact[l] : 1'b0;
    cmp_valid = 1'b1; cmp_exc = 10'(exc);
    #5;
    check("R5 completion error flag", 64'(cmp_err), 64'(!ok));
    check("R7 return-to-base", 64'(cmp_to_base), 64'($countones(mact) <= 1));
    step();
    cmp_valid = 1'b0;
    if (ok) begin
      mact[l] = 1'b0;
      if (irq_in[l]) mpend[l] = 1'b1;
    end
  endtask

  task automatic set_line(input int i, input logic v);
    irq_in[i] = v;
    step(); step();
    check("R2 synchroniser latency", 64'(pend_o[i]), 64'(mpend[i]));
    step();
    if (v) mpend[i] = 1'b1;
    check_state("R2 edge");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nchk++; nerr++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("  == %0d vectors applied, %0d miscompares ==", nchk, nerr);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    step();
    check_state("R1 reset");
    check_reads("R1 reset");

    // R2: rising edge pends, falling edge keeps
    for (int i = 0; i < NL; i++) begin
      set_line(i, 1'b1);
      set_line(i, 1'b0);
    end
    wr(3, 0, 32'hFFFF_FFFF); wr(3, 1, 32'hFFFF_FFFF);
    check_state("R9 clear all pending");

    // R8/R10: enable masks
    wr(0, 0, 32'hA5A5_00F1); check_state("R8 set enable w0");
    wr(0, 1, 32'hFFFF_FF3C); check_state("R8 set enable w1");
    check_reads("R8");
    wr(1, 0, 32'h0000_00F0); check_state("R8 clear enable w0");
    wr(1, 1, 32'h0000_0000); check_state("R8 zero mask");
    wr(1, 0, 32'h8000_0001); check_state("R8 clear enable edge bits");
    check_reads("R8 after clear");

    // R9: pending masks
    wr(2, 0, 32'h1234_5678); wr(2, 1, 32'h0000_00C3);
    check_state("R9 set pending");
    check_reads("R9");
    wr(3, 0, 32'h0000_0000); check_state("R9 zero mask");
    wr(3, 0, 32'hFFFF_0000); wr(3, 1, 32'h0000_0001);
    check_state("R9 clear pending");
    wr(3, 0, 32'hFFFF_FFFF); wr(3, 1, 32'hFFFF_FFFF);

    // R12/R3: trigger sweep over field and privilege combinations
    for (int mode = 0; mode < 4; mode++) begin
      priv_mode = mode[0]; user_pend_en = mode[1];
      for (int f = 0; f < 64; f++) begin
        wr(5, 0, 32'hFFFF_FE00 | 32'(f));
        check_state("R12 trigger");
        if (f < NL) wr(3, f / 32, 32'h1 << (f % 32));
      end
      wr(5, 0, 32'h0000_01FF);
      check_state("R12 trigger top field");
    end
    priv_mode = 1'b1; user_pend_en = 1'b0;

    // R4/R6/R7/R3: acknowledge and completion per line
    for (int i = 0; i < NL; i++) begin
      wr(2, i / 32, 32'h1 << (i % 32));
      do_ack(i + 16);  check_state("R4 ack moves to active");
      do_ack(i + 16);  check_state("R4 ack of non-pending");
      do_cmp(i + 16);  check_state("R6 completion level low");
      set_line(i, 1'b1);
      do_ack(i + 16);  check_state("R4 ack of edge-pended line");
      do_cmp(i + 16);  check_state("R6 re-pend while high");
      set_line(i, 1'b0);
      wr(3, i / 32, 32'h1 << (i % 32));
      check_state("R6 cleanup");
    end

    // R5/R3: illegal completions and unmapped acknowledges
    wr(2, 0, 32'h0000_0001);
    wr(2, 1, 32'h0000_0080);
    for (int e = 0; e < 16; e++) begin
      do_ack(e); do_cmp(e);
      check_state("R3 number below 16");
    end
    for (int e = 16 + NL; e < 16 + NL + 8; e++) begin
      do_ack(e); do_cmp(e);
      check_state("R3 number above range");
    end
    do_cmp(16 + 5); check_state("R5 completion of idle line");

    // R7/R11: nested actives
    wr(3, 0, 32'hFFFF_FFFF); wr(3, 1, 32'hFFFF_FFFF);
    wr(2, 0, 32'h0010_0008);
    do_ack(16 + 3); do_ack(16 + 20);
    check_state("R4 two active");
    wr(4, 0, 32'hFFFF_FFFF); check_state("R11 active write ignored");
    wr(4, 1, 32'hFFFF_FFFF); check_state("R11 active write ignored w1");
    check_reads("R10 active read");
    do_cmp(16 + 3);  check_state("R7 nested completion");
    do_cmp(16 + 20); check_state("R7 last completion");

    // R13: acknowledge collides with software set pending
    wr(2, 0, 32'h0000_0080);
    ack_valid = 1'b1; ack_exc = 10'(16 + 7);
    wr_en = 1'b1; wr_op = 3'd2; wr_word = '0; wr_data = 32'h0000_0080;
    step();
    ack_valid = 1'b0; wr_en = 1'b0;
    mact[7] = 1'b1; mpend[7] = 1'b1;
    check_state("R13 set beats acknowledge clear");

    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", nchk, nerr);
    $finish;
  end
endmodule